// File: doc/BRIEF.md
# Pseudo-Static RAM Power-State Controller

This block supervises the power states of a pseudo-static RAM from the pins a host drives on it: chip select, a run/standby mode pin, the two byte-lane enables, and a power-good indication. After power-good it checks the start-up sequence. The mode pin must be held low long enough. Chip select must already be high when mode rises. Both must then stay high for a settle period before the first access is allowed. From then on it tracks whether the device is active, in normal standby (all data kept), or in partial-refresh standby (only a low address window kept).

The kept window comes from a 2-bit density code that a mode register supplies. The code is latched when partial standby is entered. The controller reports the highest kept address while partial standby or its wake-up is in progress. The exit path depends on the latched code. With some data kept, a short wake delay is enough. With nothing kept, the full settle period must be repeated, and a data-lost flag stays up until it completes. Accesses made while the device is not ready are refused and flagged rather than forwarded. All delays are parameters counted in clock cycles. The pins here are plain control and status signals, so no valid/ready handshake or back-pressure applies.

Top module: `psram_power_ctrl`

## Requirements
- R1: Reset, or power-good low at a clock edge, puts the state at OFF (code 0) with ready low. With power-good high, OFF moves to INIT_LOW (code 1) at the next edge.
- R2: INIT_LOW counts consecutive edges with run_mode low. It moves to INIT_HIGH (code 2) only at an edge where run_mode is high, the count is at least T_LOW, and sel_n is high. Any other edge with run_mode high clears the count and stays in INIT_LOW.
- R3: INIT_HIGH moves to ACTIVE (code 3) after T_HIGH consecutive edges with sel_n and run_mode both high. An edge with sel_n low restarts the count. An edge with run_mode low returns to INIT_LOW.
- R4: ready is high exactly in ACTIVE and STANDBY (code 4). It can only rise when leaving INIT_HIGH or WAKE (code 6).
- R5: From ACTIVE or STANDBY, with run_mode high, the next state is STANDBY when sel_n is high or both lane enables are high. Otherwise it is ACTIVE.
- R6: From ACTIVE or STANDBY, an edge with run_mode low and sel_n high enters PARTIAL (code 5) and latches dens_code. With run_mode low and sel_n low, the state does not change.
- R7: keep_top is all ones outside PARTIAL and WAKE. Inside them it follows the latched code: 00 gives 0FFFFF, 01 gives 07FFFF, 10 gives 03FFFF, 11 gives 0. Changes of dens_code after entry have no effect.
- R8: With a latched code other than 11, run_mode high in PARTIAL moves to WAKE. WAKE reaches STANDBY after T_EXIT edges with run_mode high. run_mode low in WAKE returns to PARTIAL.
- R9: With latched code 11, run_mode high in PARTIAL moves straight to INIT_HIGH, so the full T_HIGH settle is repeated.
- R10: data_lost rises when PARTIAL is entered with code 11. It falls at the edge where INIT_HIGH completes into ACTIVE.
- R11: An access is sel_n low with at least one lane enable low. In the same cycle it raises acc_fwd when ready is high, and acc_err otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply is within range |
| sel_n | input | 1 | Chip select, active low |
| run_mode | input | 1 | High for normal operation, low for init hold or partial standby |
| lane_lo_n | input | 1 | Low byte-lane enable, active low |
| lane_hi_n | input | 1 | High byte-lane enable, active low |
| dens_code | input | 2 | Kept-window code from the mode register |
| pstate | output | 3 | Current state code (0 OFF … 6 WAKE) |
| ready | output | 1 | Accesses are allowed |
| keep_top | output | ADDR_W | Highest address whose data is kept |
| data_lost | output | 1 | Partial standby kept nothing; re-initialization pending |
| acc_fwd | output | 1 | Access passed to the array |
| acc_err | output | 1 | Access refused, protocol error |

## Verification
Several functions can land on the same cycle. An access attempt can coincide with a state change: chip select dropping during the settle period or during wake, or a partial-standby request made while chip select is still low. The access gate must then judge against the state of that cycle, while the sequencer restarts its count or holds its state. A second collision is partial entry with code 11, where data_lost and keep_top must switch on the very edge that enters PARTIAL. The bench steers these cases on purpose and compares state, ready, keep_top, data_lost and both access flags on every cycle against a behavioural model.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    PS_OFF     = 3'd0,
    PS_INIT_LO = 3'd1,
    PS_INIT_HI = 3'd2,
    PS_ACTIVE  = 3'd3,
    PS_STBY    = 3'd4,
    PS_PART    = 3'd5,
    PS_WAKE    = 3'd6
  } pstate_e;

  localparam logic [1:0] DENS_NONE = 2'b11;
endpackage

// File: rtl/psr_hold_timer.sv
module psr_hold_timer #(
  parameter int CW   = 5,
  parameter int MAXV = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (inc && cnt < TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psr_state_fsm.sv
module psr_state_fsm
  import psr_pkg::*;
#(
  parameter int T_LOW  = 8,
  parameter int T_HIGH = 20,
  parameter int T_EXIT = 3,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          sel_n,
  input  logic          run_mode,
  input  logic          lane_lo_n,
  input  logic          lane_hi_n,
  input  logic          none_kept,
  input  logic [CW-1:0] cnt,
  output pstate_e       st,
  output logic          tmr_clr,
  output logic          tmr_inc,
  output logic          part_enter,
  output logic          init_done
);
  localparam logic [CW-1:0] LOW_MIN  = CW'(T_LOW);
  localparam logic [CW-1:0] HIGH_END = CW'(T_HIGH - 1);
  localparam logic [CW-1:0] EXIT_END = CW'(T_EXIT - 1);

  pstate_e nx;

  always_comb begin
    nx         = st;
    tmr_clr    = 1'b0;
    tmr_inc    = 1'b0;
    part_enter = 1'b0;
    init_done  = 1'b0;
    if (!pwr_good) begin
      nx      = PS_OFF;
      tmr_clr = 1'b1;
    end else begin
      unique case (st)
        PS_OFF: begin
          nx      = PS_INIT_LO;
          tmr_clr = 1'b1;
        end
        PS_INIT_LO: begin
          if (!run_mode) tmr_inc = 1'b1;
          else begin
            tmr_clr = 1'b1;
            if (cnt >= LOW_MIN && sel_n) nx = PS_INIT_HI;
          end
        end
        PS_INIT_HI: begin
          if (!run_mode) begin
            nx      = PS_INIT_LO;
            tmr_clr = 1'b1;
          end else if (!sel_n) begin
            tmr_clr = 1'b1;
          end else if (cnt == HIGH_END) begin
            nx        = PS_ACTIVE;
            tmr_clr   = 1'b1;
            init_done = 1'b1;
          end else begin
            tmr_inc = 1'b1;
          end
        end
        PS_ACTIVE, PS_STBY: begin
          tmr_clr = 1'b1;
          if (!run_mode) begin
            if (sel_n) begin
              nx         = PS_PART;
              part_enter = 1'b1;
            end
          end else if (sel_n || (lane_lo_n && lane_hi_n)) begin
            nx = PS_STBY;
          end else begin
            nx = PS_ACTIVE;
          end
        end
        PS_PART: begin
          tmr_clr = 1'b1;
          if (run_mode) nx = none_kept ? PS_INIT_HI : PS_WAKE;
        end
        PS_WAKE: begin
          if (!run_mode) begin
            nx      = PS_PART;
            tmr_clr = 1'b1;
          end else if (cnt == EXIT_END) begin
            nx      = PS_STBY;
            tmr_clr = 1'b1;
          end else begin
            tmr_inc = 1'b1;
          end
        end
        default: begin
          nx      = PS_OFF;
          tmr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_OFF;
    else        st <= nx;
  end
endmodule

// File: rtl/psr_keep_range.sv
module psr_keep_range
  import psr_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          part_enter,
  input  logic          init_done,
  input  logic          in_part,
  input  logic [1:0]    dens_in,
  output logic [AW-1:0] keep_top,
  output logic          data_lost,
  output logic          none_kept
);
  localparam int NCODE = 4;

  logic [1:0]    dens_q;
  logic [AW-1:0] bound [NCODE];

  for (genvar k = 0; k < NCODE - 1; k++) begin : g_bound
    assign bound[k] = {AW{1'b1}} >> (k + 2);
  end
  assign bound[NCODE-1] = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dens_q    <= '0;
      data_lost <= 1'b0;
    end else begin
      if (part_enter) begin
        dens_q <= dens_in;
        if (dens_in == DENS_NONE) data_lost <= 1'b1;
      end else if (init_done) begin
        data_lost <= 1'b0;
      end
    end
  end

  assign none_kept = (dens_q == DENS_NONE);
  assign keep_top  = in_part ? bound[dens_q] : {AW{1'b1}};
endmodule

// File: rtl/psr_access_gate.sv
module psr_access_gate (
  input  logic sel_n,
  input  logic lane_lo_n,
  input  logic lane_hi_n,
  input  logic ready,
  output logic acc_fwd,
  output logic acc_err
);
  logic attempt;
  assign attempt = !sel_n && !(lane_lo_n && lane_hi_n);
  assign acc_fwd = attempt && ready;
  assign acc_err = attempt && !ready;
endmodule

// File: rtl/psram_power_ctrl.sv
module psram_power_ctrl
  import psr_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int T_LOW  = 8,
  parameter int T_HIGH = 20,
  parameter int T_EXIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              sel_n,
  input  logic              run_mode,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic [1:0]        dens_code,
  output logic [2:0]        pstate,
  output logic              ready,
  output logic [ADDR_W-1:0] keep_top,
  output logic              data_lost,
  output logic              acc_fwd,
  output logic              acc_err
);
  localparam int MAXV = (T_HIGH > T_LOW) ? ((T_HIGH > T_EXIT) ? T_HIGH : T_EXIT)
                                         : ((T_LOW > T_EXIT) ? T_LOW : T_EXIT);
  localparam int CW   = $clog2(MAXV + 1);

  pstate_e       st;
  logic [CW-1:0] cnt;
  logic          tmr_clr, tmr_inc, part_enter, init_done, none_kept, in_part;

  psr_hold_timer #(.CW(CW), .MAXV(MAXV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .cnt(cnt)
  );

  psr_state_fsm #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_EXIT(T_EXIT), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
    .run_mode(run_mode), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .none_kept(none_kept), .cnt(cnt), .st(st), .tmr_clr(tmr_clr),
    .tmr_inc(tmr_inc), .part_enter(part_enter), .init_done(init_done)
  );

  assign in_part = (st == PS_PART) || (st == PS_WAKE);

  psr_keep_range #(.AW(ADDR_W)) u_rng (
    .clk(clk), .rst_n(rst_n), .part_enter(part_enter), .init_done(init_done),
    .in_part(in_part), .dens_in(dens_code), .keep_top(keep_top),
    .data_lost(data_lost), .none_kept(none_kept)
  );

  assign ready  = (st == PS_ACTIVE) || (st == PS_STBY);
  assign pstate = st;

  psr_access_gate u_gate (
    .sel_n(sel_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .ready(ready), .acc_fwd(acc_fwd), .acc_err(acc_err)
  );
endmodule

// File: rtl/psr_power_checker.sv
module psr_power_checker #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_good,
  input logic          sel_n,
  input logic          run_mode,
  input logic [2:0]    pstate,
  input logic          ready,
  input logic [AW-1:0] keep_top,
  input logic          data_lost
);
  assert_power_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (pstate == 3'd0 && !ready));

  assert_init_low_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd1) |=> (pstate <= 3'd2));

  assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(pstate) == 3'd2 || $past(pstate) == 3'd6));

  assert_hold_when_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pstate == 3'd3 || pstate == 3'd4) && !run_mode && !sel_n && pwr_good)
      |=> (pstate == $past(pstate)));

  assert_bound_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd5 && $past(pstate) == 3'd5) |-> $stable(keep_top));

  assert_wake_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd6 && !run_mode && pwr_good) |=> (pstate == 3'd5));

  assert_empty_reinit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd5 && run_mode && pwr_good && keep_top == '0) |=> (pstate == 3'd2));

  assert_lost_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> (pstate == 3'd5 &&
                          ($past(pstate) == 3'd3 || $past(pstate) == 3'd4)));
endmodule

bind psram_power_ctrl psr_power_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
  .run_mode(run_mode), .pstate(pstate), .ready(ready),
  .keep_top(keep_top), .data_lost(data_lost)
);

// File: tb/test_psram_power_ctrl.sv
module test_psram_power_ctrl;
  localparam int AW = 22, TL = 8, TH = 20, TE = 3;

  logic clk = 1'b0;
  logic rst_n, pwr_good, sel_n, run_mode, lane_lo_n, lane_hi_n;
  logic [1:0] dens_code;
  logic [2:0] pstate;
  logic ready, data_lost, acc_fwd, acc_err;
  logic [AW-1:0] keep_top;

  int checks = 0, errors = 0;
  int m_st = 0, m_cnt = 0, m_dens = 0, m_lost = 0;

  always #5 clk = ~clk;

  psram_power_ctrl #(.ADDR_W(AW), .T_LOW(TL), .T_HIGH(TH), .T_EXIT(TE)) i_psram_power_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
    .run_mode(run_mode), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .dens_code(dens_code), .pstate(pstate), .ready(ready),
    .keep_top(keep_top), .data_lost(data_lost), .acc_fwd(acc_fwd), .acc_err(acc_err)
  );

  function automatic logic [AW-1:0] bound_of(int code);
    case (code)
      0: return 22'h0FFFFF;
      1: return 22'h07FFFF;
      2: return 22'h03FFFF;
      default: return 22'h000000;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      5: return "R6";
      6: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_dens = 0; m_lost = 0;
    end else if (!pwr_good) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_cnt = 0; end
        1: if (!run_mode) begin
             if (m_cnt < TL) m_cnt++;
           end else begin
             if (m_cnt >= TL && sel_n) m_st = 2;
             m_cnt = 0;
           end
        2: if (!run_mode) begin m_st = 1; m_cnt = 0; end
           else if (!sel_n) m_cnt = 0;
           else if (m_cnt == TH - 1) begin m_st = 3; m_cnt = 0; m_lost = 0; end
           else m_cnt++;
        3, 4: if (!run_mode) begin
                if (sel_n) begin
                  m_st = 5; m_dens = dens_code;
                  if (dens_code == 2'b11) m_lost = 1;
                end
              end else if (sel_n || (lane_lo_n && lane_hi_n)) m_st = 4;
              else m_st = 3;
        5: if (run_mode) begin m_st = (m_dens == 3) ? 2 : 6; m_cnt = 0; end
        6: if (!run_mode) begin m_st = 5; m_cnt = 0; end
           else if (m_cnt == TE - 1) begin m_st = 4; m_cnt = 0; end
           else m_cnt++;
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit rdy  = (m_st == 3 || m_st == 4);
      automatic bit acc  = !sel_n && !(lane_lo_n && lane_hi_n);
      automatic logic [AW-1:0] kt = (m_st == 5 || m_st == 6) ? bound_of(m_dens) : '1;
      check(tag_of(m_st), pstate, m_st, "state");
      check("R4", ready, rdy, "ready");
      check("R7", keep_top, kt, "keep_top");
      check("R10", data_lost, m_lost, "data_lost");
      check("R11", acc_fwd, acc && rdy, "acc_fwd");
      check("R11", acc_err, acc && !rdy, "acc_err");
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pwr_good = 0; sel_n = 1; run_mode = 0;
    lane_lo_n = 1; lane_hi_n = 1; dens_code = 2'b00;
    cyc(3); rst_n = 1; cyc(2);
    check("R1", pstate, 0, "state held off without power-good");
    check("R1", ready, 0, "ready during off");
    pwr_good = 1; cyc(1);
    check("R1", pstate, 1, "off to init-low");
    // R2: too-short low period, then mode rise with select low
    cyc(3); run_mode = 1; cyc(1);
    check("R2", pstate, 1, "early mode rise ignored");
    run_mode = 0; cyc(10); sel_n = 0; run_mode = 1; cyc(1);
    check("R2", pstate, 1, "mode rise with select low ignored");
    run_mode = 0; sel_n = 1; cyc(9); run_mode = 1; cyc(1);
    check("R2", pstate, 2, "init-low to init-high");
    // R3 with access attempt during settle (R11 collision)
    cyc(5); sel_n = 0; lane_lo_n = 0; cyc(1);
    sel_n = 1; lane_lo_n = 1; cyc(TH - 1);
    check("R3", pstate, 2, "settle restarted by select");
    cyc(1);
    check("R3", pstate, 3, "settle complete");
    // R5
    sel_n = 0; lane_lo_n = 0; lane_hi_n = 0; cyc(3);
    check("R5", pstate, 3, "active with lanes on");
    lane_lo_n = 1; lane_hi_n = 1; cyc(1);
    check("R5", pstate, 4, "both lanes off gives standby");
    lane_lo_n = 0; cyc(1);
    check("R5", pstate, 3, "lane on returns active");
    sel_n = 1; lane_lo_n = 1; cyc(1);
    check("R5", pstate, 4, "deselect gives standby");
    check("R4", ready, 1, "ready in standby");
    // R6/R7 density 01, later change ignored
    dens_code = 2'b01; run_mode = 0; cyc(1);
    check("R6", pstate, 5, "partial entry");
    check("R7", keep_top, 22'h07FFFF, "bound code 01");
    dens_code = 2'b10; cyc(2);
    check("R7", keep_top, 22'h07FFFF, "bound latched");
    // R8 wake, abort, wake
    run_mode = 1; cyc(1);
    check("R8", pstate, 6, "wake");
    check("R4", ready, 0, "not ready in wake");
    sel_n = 0; lane_lo_n = 0; cyc(1);
    run_mode = 0; sel_n = 1; lane_lo_n = 1; cyc(1);
    check("R8", pstate, 5, "wake aborted");
    run_mode = 1; cyc(1 + TE - 1);
    check("R8", pstate, 6, "still waking");
    cyc(1);
    check("R8", pstate, 4, "wake done");
    // R6 mode low with select low holds
    sel_n = 0; lane_lo_n = 0; cyc(1);
    run_mode = 0; cyc(2);
    check("R6", pstate, 3, "no entry while selected");
    sel_n = 1; lane_lo_n = 1; cyc(1);
    check("R7", keep_top, 22'h03FFFF, "bound code 10");
    run_mode = 1; cyc(1 + TE);
    check("R8", pstate, 4, "code 10 wake");
    dens_code = 2'b00; run_mode = 0; cyc(1);
    check("R7", keep_top, 22'h0FFFFF, "bound code 00");
    run_mode = 1; cyc(1 + TE);
    check("R7", keep_top, 22'h3FFFFF, "full range outside partial");
    // R9/R10 nothing kept
    dens_code = 2'b11; run_mode = 0; cyc(1);
    check("R10", data_lost, 1, "lost on empty entry");
    check("R7", keep_top, 22'h000000, "bound code 11");
    run_mode = 1; cyc(1);
    check("R9", pstate, 2, "empty exit re-inits");
    cyc(TH - 1);
    check("R9", pstate, 2, "full settle repeated");
    cyc(1);
    check("R9", pstate, 3, "active after re-init");
    check("R10", data_lost, 0, "lost cleared");
    sel_n = 0; lane_lo_n = 0; cyc(1);
    sel_n = 1; lane_lo_n = 1; pwr_good = 0; cyc(1);
    check("R1", pstate, 0, "power loss");
    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule